// File: doc/BRIEF.md
# Serial Port Error Flag Controller

This block collects the error conditions of a synchronous serial port that can act as bus master or as slave. The shift engine sends it one-cycle strobes: a frame has finished, software has read the receive word, the transmitter ran dry, or the slave clock rate drifted. The block also watches the serial data input for a data change that falls too close to a sampling edge. Each condition sets a sticky flag. Two of the four conditions only count while the port is a slave.

The block also holds the single-word receive buffer. When a frame finishes before the previous word was read, the new word replaces the old one and the overrun flag is raised. A per-flag enable from the control register selects which flags drive the single registered interrupt line. Software clears flags by writing ones to a clear port.

Flag bit positions are fixed: bit 0 transmit underrun, bit 1 receive overrun, bit 2 phase, bit 3 clock-rate. The same positions are used for the enable and clear vectors.

Top module: `sio_err_ctl`

## Requirements
- R1: A synchronous reset clears `flags_o`, `eirq_o` and `rb_full_o` to 0.
- R2: When `frame_done_i` is high, `rx_word_i` is loaded into `rb_data_o` and `rb_full_o` is set after the edge. A cycle with `rb_rd_i` high and no `frame_done_i` clears `rb_full_o`.
- R3: Overrun. A `frame_done_i` while `rb_full_o` is 1 and `rb_rd_i` is 0 sets flag bit 1 after the edge, and the new word replaces the old one.
- R4: No overrun is flagged when `frame_done_i` arrives while the buffer is empty, or in the same cycle as `rb_rd_i`.
- R5: Phase. A change of `din_i` that lies within WIN cycles (either side, inclusive) of a `samp_edge_i` cycle sets flag bit 2, two edges after the later of the two events. A change WIN+1 or more cycles away does not set it.
- R6: With `master_i` = 0, `tx_under_i` sets flag bit 0 and `baud_dev_i` sets flag bit 3.
- R7: With `master_i` = 1, `tx_under_i` and `baud_dev_i` have no effect on the flags.
- R8: Flags are sticky. A write with `clr_we_i` high clears exactly the bits where `clr_data_i` is 1. Zeros in `clr_data_i` leave their flags unchanged.
- R9: When a set event and a clear of the same bit occur in the same cycle, the flag ends up set.
- R10: `eirq_o` equals the OR over bits of (`flags_o` AND `err_en_i`), registered one cycle after the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| err_en_i | input | 4 | Per-flag interrupt enable |
| frame_done_i | input | 1 | Frame received strobe |
| rx_word_i | input | W | Word received with the frame |
| rb_rd_i | input | 1 | Receive buffer read strobe |
| rb_data_o | output | W | Receive buffer contents |
| rb_full_o | output | 1 | Receive buffer holds an unread word |
| tx_under_i | input | 1 | Transmit underrun strobe |
| baud_dev_i | input | 1 | Clock-rate deviation strobe |
| din_i | input | 1 | Serial data input as seen at the module clock |
| samp_edge_i | input | 1 | Sampling edge strobe |
| clr_we_i | input | 1 | Flag clear write enable |
| clr_data_i | input | 4 | Write 1 to clear a flag |
| flags_o | output | 4 | Sticky error flags |
| eirq_o | output | 1 | Combined error interrupt |

## Verification
The interrupt combine is swept over all 16 flag patterns crossed with all 16 enable values. This separates a wrong bit mapping, a missing enable gate and an AND/OR swap. The phase detector is swept with the data change placed at every offset from WIN+2 cycles before a sampling edge to WIN+2 cycles after it. This exposes off-by-one window bounds and asymmetry between the two sides. Directed sequences cover:
- overrun against a same-cycle read;
- the slave-only strobes in both modes;
- clears with mixed zero and one bits;
- a set colliding with a clear.

// File: rtl/sio_err_pkg.sv
package sio_err_pkg;
  localparam int NERR   = 4;
  localparam int IDX_TE = 0;
  localparam int IDX_RE = 1;
  localparam int IDX_PE = 2;
  localparam int IDX_BE = 3;
  // flags that count only while the port is a slave
  localparam logic [NERR-1:0] SLAVE_ONLY = (NERR'(1) << IDX_TE) | (NERR'(1) << IDX_BE);
endpackage

// File: rtl/sio_rxbuf.sv
module sio_rxbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_done_i,
  input  logic [W-1:0] rx_word_i,
  input  logic         rb_rd_i,
  output logic [W-1:0] rb_data_o,
  output logic         rb_full_o,
  output logic         ovr_o
);
  logic [W-1:0] word_q;
  logic         full_q;

  // overrun: new frame lands on an unread word
  assign ovr_o = frame_done_i & full_q & ~rb_rd_i;

  // data register without reset so it maps to plain fabric or RAM
  always_ff @(posedge clk) begin
    if (frame_done_i) word_q <= rx_word_i;
  end

  always_ff @(posedge clk) begin
    if (rst)               full_q <= 1'b0;
    else if (frame_done_i) full_q <= 1'b1;
    else if (rb_rd_i)      full_q <= 1'b0;
  end

  assign rb_data_o = word_q;
  assign rb_full_o = full_q;
endmodule

// File: rtl/sio_phase_det.sv
module sio_phase_det #(
  parameter int WIN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  input  logic samp_edge_i,
  output logic hit_o
);
  localparam int CW = $clog2(WIN + 2);
  localparam logic [CW-1:0] FAR  = CW'(WIN + 1);
  localparam logic [CW-1:0] WLIM = CW'(WIN);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          din_q;
  logic          chg;
  logic [CW-1:0] since_chg, since_edge, d_chg;
  logic          hit_a, hit_b;

  assign chg   = din_i ^ din_q;
  assign d_chg = chg ? '0 : since_chg;
  // edge now, change at most WIN cycles ago (or now)
  assign hit_a = samp_edge_i & (d_chg <= WLIM);
  // change now, edge at most WIN cycles ago
  assign hit_b = chg & (since_edge <= WLIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q      <= 1'b0;
      since_chg  <= FAR;
      since_edge <= FAR;
      hit_o      <= 1'b0;
    end else begin
      din_q <= din_i;
      if (chg)                  since_chg <= ONE;
      else if (since_chg != FAR) since_chg <= since_chg + ONE;
      if (samp_edge_i)           since_edge <= ONE;
      else if (since_edge != FAR) since_edge <= since_edge + ONE;
      hit_o <= hit_a | hit_b;
    end
  end
endmodule

// File: rtl/sio_err_flags.sv
module sio_err_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_data_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                             flag_q[i] <= 1'b0;
      else if (set_i[i])                   flag_q[i] <= 1'b1;
      else if (clr_we_i && clr_data_i[i])  flag_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flag_q & en_i);
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/sio_err_ctl.sv
module sio_err_ctl #(
  parameter int W   = 8,
  parameter int WIN = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         master_i,
  input  logic [3:0]   err_en_i,
  input  logic         frame_done_i,
  input  logic [W-1:0] rx_word_i,
  input  logic         rb_rd_i,
  output logic [W-1:0] rb_data_o,
  output logic         rb_full_o,
  input  logic         tx_under_i,
  input  logic         baud_dev_i,
  input  logic         din_i,
  input  logic         samp_edge_i,
  input  logic         clr_we_i,
  input  logic [3:0]   clr_data_i,
  output logic [3:0]   flags_o,
  output logic         eirq_o
);
  import sio_err_pkg::*;

  logic            ovr, ph_hit;
  logic [NERR-1:0] raw_ev, mode_mask, set_ev;

  sio_rxbuf #(.W(W)) u_rxbuf (
    .clk(clk), .rst(rst), .frame_done_i(frame_done_i), .rx_word_i(rx_word_i),
    .rb_rd_i(rb_rd_i), .rb_data_o(rb_data_o), .rb_full_o(rb_full_o), .ovr_o(ovr)
  );

  sio_phase_det #(.WIN(WIN)) u_phase (
    .clk(clk), .rst(rst), .din_i(din_i), .samp_edge_i(samp_edge_i), .hit_o(ph_hit)
  );

  always_comb begin
    raw_ev         = '0;
    raw_ev[IDX_TE] = tx_under_i;
    raw_ev[IDX_RE] = ovr;
    raw_ev[IDX_PE] = ph_hit;
    raw_ev[IDX_BE] = baud_dev_i;
  end

  assign mode_mask = SLAVE_ONLY & {NERR{master_i}};
  assign set_ev    = raw_ev & ~mode_mask;

  sio_err_flags #(.N(NERR)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_ev), .clr_we_i(clr_we_i),
    .clr_data_i(clr_data_i), .en_i(err_en_i), .flags_o(flags_o), .irq_o(eirq_o)
  );
endmodule

// File: rtl/sio_err_chk.sv
module sio_err_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         master_i,
  input logic [3:0]   err_en_i,
  input logic         frame_done_i,
  input logic [W-1:0] rx_word_i,
  input logic         rb_rd_i,
  input logic [W-1:0] rb_data_o,
  input logic         rb_full_o,
  input logic         clr_we_i,
  input logic [3:0]   clr_data_i,
  input logic [3:0]   flags_o,
  input logic         eirq_o
);
  // R2
  rb_load_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done_i |=> (rb_full_o && rb_data_o == $past(rx_word_i)));

  // R3
  ovr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done_i && rb_full_o && !rb_rd_i) |=> flags_o[1]);

  // R7
  master_te_chk: assert property (@(posedge clk) disable iff (rst)
    (master_i && !flags_o[0]) |=> !flags_o[0]);

  // R7
  master_be_chk: assert property (@(posedge clk) disable iff (rst)
    (master_i && !flags_o[3]) |=> !flags_o[3]);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~flags_o & $past(flags_o) & ~($past(clr_data_i) & {4{$past(clr_we_i)}})) == 4'b0));

  // R10
  irq_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (eirq_o == $past(|(flags_o & err_en_i))));
endmodule

bind sio_err_ctl sio_err_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .master_i(master_i), .err_en_i(err_en_i),
  .frame_done_i(frame_done_i), .rx_word_i(rx_word_i), .rb_rd_i(rb_rd_i),
  .rb_data_o(rb_data_o), .rb_full_o(rb_full_o), .clr_we_i(clr_we_i),
  .clr_data_i(clr_data_i), .flags_o(flags_o), .eirq_o(eirq_o)
);

// File: tb/sim_sio_err_ctl.sv
`timescale 1ns/1ps
module sim_sio_err_ctl;
  localparam int W = 8;
  localparam int WIN = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic master_i = 1'b0;
  logic [3:0] err_en_i = '0;
  logic frame_done_i = 1'b0, rb_rd_i = 1'b0;
  logic [W-1:0] rx_word_i = '0;
  logic [W-1:0] rb_data_o;
  logic rb_full_o, eirq_o;
  logic tx_under_i = 1'b0, baud_dev_i = 1'b0, din_i = 1'b0, samp_edge_i = 1'b0;
  logic clr_we_i = 1'b0;
  logic [3:0] clr_data_i = '0;
  logic [3:0] flags_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sio_err_ctl #(.W(W), .WIN(WIN)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inputs change right after the falling edge; one call = one rising edge
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_done_i = 0; rb_rd_i = 0; tx_under_i = 0; baud_dev_i = 0;
      samp_edge_i = 0; clr_we_i = 0;
    end
  endtask

  task automatic clear_all();
    clr_we_i = 1; clr_data_i = 4'hF; rb_rd_i = 1;
    step(2);
  endtask

  task automatic make_flags(input logic [3:0] pat);
    clear_all();
    if (pat[1]) begin frame_done_i = 1; rx_word_i = 8'h11; step(); end
    tx_under_i = pat[0]; baud_dev_i = pat[3];
    frame_done_i = pat[1]; rx_word_i = 8'h22;
    if (pat[2]) begin samp_edge_i = 1; din_i = ~din_i; end
    step(3);
  endtask

  initial begin
    step(3);
    rst = 0;
    chk(flags_o == 0 && eirq_o == 0 && rb_full_o == 0, "R1 reset", {flags_o, eirq_o, rb_full_o}, 0);

    // R2 load and read
    frame_done_i = 1; rx_word_i = 8'hA5; step();
    chk(rb_full_o && rb_data_o == 8'hA5, "R2 load", rb_data_o, 8'hA5);
    rb_rd_i = 1; step();
    chk(!rb_full_o, "R2 read clears full", rb_full_o, 0);

    // R4 empty buffer: no overrun
    frame_done_i = 1; rx_word_i = 8'h3C; step();
    chk(flags_o[1] == 0, "R4 empty", flags_o, 0);
    // R4 read in same cycle: no overrun
    frame_done_i = 1; rb_rd_i = 1; rx_word_i = 8'h5A; step();
    chk(flags_o[1] == 0 && rb_full_o && rb_data_o == 8'h5A, "R4 same-cycle read", flags_o, 0);
    // R3 overrun with overwrite
    frame_done_i = 1; rx_word_i = 8'hC3; step();
    chk(flags_o[1] == 1, "R3 overrun flag", flags_o, 2);
    chk(rb_data_o == 8'hC3, "R3 overwrite", rb_data_o, 8'hC3);

    // R8 zero clear leaves flag; one clear removes it
    clr_we_i = 1; clr_data_i = 4'b1101; step();
    chk(flags_o[1] == 1, "R8 zero bit keeps", flags_o, 2);
    clr_we_i = 1; clr_data_i = 4'b0010; step();
    chk(flags_o == 0, "R8 clear", flags_o, 0);
    step(4);
    chk(flags_o == 0, "R8 stays clear", flags_o, 0);

    // R9 set beats clear (buffer still full)
    frame_done_i = 1; clr_we_i = 1; clr_data_i = 4'hF; step();
    chk(flags_o[1] == 1, "R9 set wins", flags_o, 2);
    clear_all();

    // R6 slave strobes
    master_i = 0; tx_under_i = 1; step();
    chk(flags_o == 4'b0001, "R6 transmit underrun", flags_o, 1);
    baud_dev_i = 1; step();
    chk(flags_o == 4'b1001, "R6 clock-rate", flags_o, 9);
    clear_all();
    // R7 master ignores them
    master_i = 1; tx_under_i = 1; baud_dev_i = 1; step(3);
    chk(flags_o == 0, "R7 master ignore", flags_o, 0);
    master_i = 0;

    // R5 phase window sweep
    step(WIN + 4);
    for (int off = -(WIN + 2); off <= WIN + 2; off++) begin
      clear_all();
      step(WIN + 4);
      for (int t = 0; t <= 2 * (WIN + 2); t++) begin
        if (t == WIN + 2) samp_edge_i = 1;
        if (t == WIN + 2 + off) din_i = ~din_i;
        step();
      end
      step(3);
      chk(flags_o[2] == ((off <= WIN && off >= -WIN) ? 1'b1 : 1'b0),
          $sformatf("R5 phase offset %0d", off), flags_o[2],
          (off <= WIN && off >= -WIN) ? 1 : 0);
    end

    // R10 interrupt combine, exhaustive
    for (int p = 0; p < 16; p++) begin
      make_flags(4'(p));
      chk(flags_o == 4'(p), "R10 flag pattern", flags_o, p);
      for (int e = 0; e < 16; e++) begin
        err_en_i = 4'(e); step(2);
        chk(eirq_o == ((p & e) != 0), $sformatf("R10 irq p=%0d e=%0d", p, e), eirq_o, (p & e) != 0);
      end
      err_en_i = 0;
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule